// File: doc/BRIEF.md
# Time-Triggered Transmit Command Scheduler

This block decides when each outgoing virtual link may start moving its frame from memory to the Ethernet interface. A free-running timebase cuts a 128 ms hyperperiod into 4096 equal slots of 31.25 µs. The slots are grouped as 128 lines of 1 ms with 32 columns each. A schedule memory gives every slot either no owner or exactly one link. A link with a gap of N ms is placed in the same column of every N-th line, so it gets one slot per gap period.

Producers post a message for a link together with the memory address of its data. At the start of each slot the block reads that slot's owner. When the owner has a message pending, the block pushes a transmit command (link number and buffer address) into the downstream command queue. A message that becomes ready once its slot has begun is not sent early or late in that slot: it waits for the link's next assigned slot. Because no slot has two owners, no two links ever start a transfer together.

The schedule is written through a simple write port while the scheduler is stopped. When the scheduler is disabled the timebase rests at slot 0.

Top module: `txslot_sched`

## Requirements
- R1: While enabled, `slot_idx` starts at 0 in the first enabled cycle and advances by one every SLOT_CYCLES clocks. Bits [11:5] give the line and bits [4:0] give the column. After 4095 it wraps to 0.
- R2: After reset, `cmd_push` and `ovf_err` are low, `slot_idx` is 0, and no link has a pending message.
- R3: A slot begins in the cycle where the slot counter is at its first clock. If that slot's entry is valid, its link is pending and `cmdq_full` is low, `cmd_push` is high for exactly the next cycle. In that cycle `cmd_link` carries the link and `cmd_addr` carries the stored address, and the link's pending flag is cleared.
- R4: A slot whose entry is invalid, or whose link has no pending message, produces neither `cmd_push` nor `ovf_err`.
- R5: A request that is accepted in a slot-start cycle or later does not take part in that slot's decision. It is sent at the link's next assigned slot.
- R6: If `cmdq_full` is high in a slot-start cycle that would issue a command, no command is pushed. `ovf_err` pulses in the next cycle with `ovf_link` set to the link, and the message is discarded.
- R7: Writes to the schedule while the scheduler is enabled are ignored.
- R8: A request can arrive for a link in the same cycle that link's command is issued. In that case the command carries the previously stored address, and the new message stays pending for the next assigned slot.
- R9: Two consecutive cycles never both carry `cmd_push`.
- R10: While disabled, `slot_idx` stays 0 and no command or overflow is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sched_en | input | 1 | Run the timebase and scheduling; low holds slot 0 |
| req_valid | input | 1 | Post a message for `req_link` |
| req_link | input | 5 | Link of the posted message |
| req_addr | input | 32 | Memory address of the message data |
| tbl_we | input | 1 | Schedule write strobe (acted on only while disabled) |
| tbl_slot | input | 12 | Slot written: line in [11:5], column in [4:0] |
| tbl_valid | input | 1 | Written entry owns its slot |
| tbl_link | input | 5 | Link owning the written slot |
| cmdq_full | input | 1 | Downstream command queue cannot accept a push |
| cmd_push | output | 1 | Push a transmit command this cycle |
| cmd_link | output | 5 | Link of the pushed command |
| cmd_addr | output | 32 | Buffer address of the pushed command |
| ovf_err | output | 1 | A scheduled command was dropped because the queue was full |
| ovf_link | output | 5 | Link of the dropped command |
| slot_idx | output | 12 | Current slot of the hyperperiod |

## Verification
Two events can collide in one cycle: a producer posting a message, and the scheduler issuing a command for the same link in that slot's start cycle. The bench aims requests exactly at slot-start cycles. It checks that a fresh message on a non-pending link waits a full line, and that on a pending link the issued command keeps the old address while the new one leaves on the following assigned slot. A random phase repeats the same collisions with periodic schedules and a queue that is sometimes full. Every cycle is compared against a reference model written from the requirements.

// File: rtl/txsched_pkg.sv
package txsched_pkg;
    localparam int LINE_BITS = 7;
    localparam int COL_BITS  = 5;
    localparam int SLOT_BITS = LINE_BITS + COL_BITS;
    localparam int LINK_BITS = 5;
    localparam int NUM_LINKS = 1 << LINK_BITS;
    localparam int ADDR_BITS = 32;

    typedef logic [SLOT_BITS-1:0] slot_t;
    typedef logic [LINK_BITS-1:0] link_t;
    typedef logic [ADDR_BITS-1:0] addr_t;

    typedef struct packed {
        logic  valid;
        link_t link;
    } entry_t;
endpackage

// File: rtl/txsched_timer.sv
module txsched_timer
    import txsched_pkg::*;
#(
    parameter int SLOT_CYCLES = 7812
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    output slot_t slot,
    output slot_t slot_next,
    output logic  slot_start
);
    localparam int CNT_BITS = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [CNT_BITS-1:0] CNT_LAST = CNT_BITS'(SLOT_CYCLES - 1);

    typedef struct packed {
        logic [CNT_BITS-1:0] cnt;
        slot_t               slot;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.cnt  = '0;
            st_d.slot = '0;
        end else if (st_q.cnt == CNT_LAST) begin
            st_d.cnt  = '0;
            st_d.slot = st_q.slot + slot_t'(1);
        end else begin
            st_d.cnt = st_q.cnt + CNT_BITS'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot       = st_q.slot;
    assign slot_next  = st_d.slot;
    assign slot_start = en && (st_q.cnt == '0);
endmodule

// File: rtl/txsched_table.sv
module txsched_table
    import txsched_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  slot_t  wr_slot,
    input  entry_t wr_entry,
    input  slot_t  rd_slot,
    output entry_t rd_entry
);
    localparam int DEPTH = 1 << SLOT_BITS;

    entry_t mem [DEPTH];
    entry_t rd_d, rd_q;

    always_comb begin
        if (wr_en && (wr_slot == rd_slot)) rd_d = wr_entry;
        else                               rd_d = mem[rd_slot];
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_slot] <= wr_entry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_entry = rd_q;
endmodule

// File: rtl/txsched_links.sv
module txsched_links
    import txsched_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req_valid,
    input  link_t req_link,
    input  addr_t req_addr,
    input  logic  clr,
    input  link_t clr_link,
    input  link_t look_link,
    output logic  look_ready,
    output addr_t look_addr
);
    logic [NUM_LINKS-1:0] rdy_vec;
    addr_t                addr_arr [NUM_LINKS];

    for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
        typedef struct packed {
            logic  rdy;
            addr_t addr;
        } lnk_t;

        lnk_t l_d, l_q;

        always_comb begin
            l_d = l_q;
            if (clr && (clr_link == link_t'(i))) l_d.rdy = 1'b0;
            if (req_valid && (req_link == link_t'(i))) begin
                l_d.rdy  = 1'b1;
                l_d.addr = req_addr;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) l_q <= '0;
            else        l_q <= l_d;
        end

        assign rdy_vec[i]  = l_q.rdy;
        assign addr_arr[i] = l_q.addr;
    end

    assign look_ready = rdy_vec[look_link];
    assign look_addr  = addr_arr[look_link];
endmodule

// File: rtl/txslot_sched.sv
module txslot_sched
    import txsched_pkg::*;
#(
    parameter int SLOT_CYCLES = 7812
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sched_en,
    input  logic                 req_valid,
    input  logic [LINK_BITS-1:0] req_link,
    input  logic [ADDR_BITS-1:0] req_addr,
    input  logic                 tbl_we,
    input  logic [SLOT_BITS-1:0] tbl_slot,
    input  logic                 tbl_valid,
    input  logic [LINK_BITS-1:0] tbl_link,
    input  logic                 cmdq_full,
    output logic                 cmd_push,
    output logic [LINK_BITS-1:0] cmd_link,
    output logic [ADDR_BITS-1:0] cmd_addr,
    output logic                 ovf_err,
    output logic [LINK_BITS-1:0] ovf_link,
    output logic [SLOT_BITS-1:0] slot_idx
);
    typedef struct packed {
        logic  push;
        link_t link;
        addr_t addr;
        logic  err;
        link_t err_link;
    } out_t;

    slot_t  cur_slot, nxt_slot;
    logic   slot_start;
    entry_t ent;
    logic   look_ready;
    addr_t  look_addr;
    logic   hit;
    out_t   o_d, o_q;

    txsched_timer #(.SLOT_CYCLES(SLOT_CYCLES)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (sched_en),
        .slot       (cur_slot),
        .slot_next  (nxt_slot),
        .slot_start (slot_start)
    );

    txsched_table i_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we && !sched_en),
        .wr_slot  (tbl_slot),
        .wr_entry ('{valid: tbl_valid, link: tbl_link}),
        .rd_slot  (nxt_slot),
        .rd_entry (ent)
    );

    txsched_links i_links (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_link   (req_link),
        .req_addr   (req_addr),
        .clr        (hit),
        .clr_link   (ent.link),
        .look_link  (ent.link),
        .look_ready (look_ready),
        .look_addr  (look_addr)
    );

    assign hit = slot_start && ent.valid && look_ready;

    always_comb begin
        o_d      = o_q;
        o_d.push = 1'b0;
        o_d.err  = 1'b0;
        if (hit) begin
            if (cmdq_full) begin
                o_d.err      = 1'b1;
                o_d.err_link = ent.link;
            end else begin
                o_d.push = 1'b1;
                o_d.link = ent.link;
                o_d.addr = look_addr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign cmd_push = o_q.push;
    assign cmd_link = o_q.link;
    assign cmd_addr = o_q.addr;
    assign ovf_err  = o_q.err;
    assign ovf_link = o_q.err_link;
    assign slot_idx = cur_slot;
endmodule

// File: rtl/txsched_chk.sv
module txsched_chk
    import txsched_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sched_en,
    input logic                 cmdq_full,
    input logic                 cmd_push,
    input logic                 ovf_err,
    input logic [SLOT_BITS-1:0] slot_idx
);
    assert_slot_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sched_en) && (slot_idx != $past(slot_idx))) |-> (slot_idx == $past(slot_idx) + slot_t'(1)));

    assert_push_needs_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_push |-> !$past(cmdq_full));

    assert_err_needs_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |-> $past(cmdq_full));

    assert_push_xor_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_push && ovf_err));

    assert_push_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_push |=> !cmd_push);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sched_en) |-> (!cmd_push && !ovf_err && (slot_idx == '0)));
endmodule

bind txslot_sched txsched_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sched_en  (sched_en),
    .cmdq_full (cmdq_full),
    .cmd_push  (cmd_push),
    .ovf_err   (ovf_err),
    .slot_idx  (slot_idx)
);

// File: tb/test_txslot_sched.sv
module test_txslot_sched;
    localparam int SC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sched_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_link = '0;
    logic [31:0] req_addr = '0;
    logic        tbl_we = 1'b0;
    logic [11:0] tbl_slot = '0;
    logic        tbl_valid = 1'b0;
    logic [4:0]  tbl_link = '0;
    logic        cmdq_full = 1'b0;
    logic        cmd_push;
    logic [4:0]  cmd_link;
    logic [31:0] cmd_addr;
    logic        ovf_err;
    logic [4:0]  ovf_link;
    logic [11:0] slot_idx;

    always #2 clk = ~clk;

    txslot_sched #(.SLOT_CYCLES(SC)) i_txslot_sched (.*);

    int nchk = 0, nfail = 0, cyc = 0;
    bit done = 0;

    bit        mv  [4096];
    bit [4:0]  ml  [4096];
    bit        mrdy [32];
    bit [31:0] madr [32];
    int        mcnt = 0, mslot = 0;
    bit        ep, ee;
    bit [4:0]  el;
    bit [31:0] ea;

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag);
        ep = 0; ee = 0;
        if (sched_en && mcnt == 0) begin
            if (mv[mslot] && mrdy[ml[mslot]]) begin
                el = ml[mslot];
                ea = madr[el];
                if (cmdq_full) ee = 1; else ep = 1;
                mrdy[el] = 0;
            end
        end
        if (req_valid) begin mrdy[req_link] = 1; madr[req_link] = req_addr; end
        if (tbl_we && !sched_en) begin mv[tbl_slot] = tbl_valid; ml[tbl_slot] = tbl_link; end
        if (!sched_en) begin mcnt = 0; mslot = 0; end
        else if (mcnt == SC - 1) begin mcnt = 0; mslot = (mslot + 1) % 4096; end
        else mcnt++;
        @(negedge clk);
        check(cmd_push == ep, tag, "cmd_push", cmd_push, ep);
        if (ep) begin
            check(cmd_link == el, tag, "cmd_link", cmd_link, el);
            check(cmd_addr == ea, tag, "cmd_addr", cmd_addr, ea);
        end
        check(ovf_err == ee, "R6", "ovf_err", ovf_err, ee);
        if (ee) check(ovf_link == el, "R6", "ovf_link", ovf_link, el);
        check(slot_idx == 12'(mslot), "R1", "slot_idx", slot_idx, mslot);
    endtask

    task automatic wr(int s, bit v, int l, string tag);
        tbl_we = 1; tbl_slot = 12'(s); tbl_valid = v; tbl_link = 5'(l);
        step(tag);
        tbl_we = 0;
    endtask

    task automatic post(int l, bit [31:0] a, string tag);
        req_valid = 1; req_link = 5'(l); req_addr = a;
        step(tag);
        req_valid = 0;
    endtask

    task automatic run_to(int k, string tag);
        while (!(mslot == k && mcnt == 0)) step(tag);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            nfail++; nchk++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        check(!cmd_push && !ovf_err, "R2", "push|err", {cmd_push, ovf_err}, 0);
        check(slot_idx == 0, "R2", "slot_idx", slot_idx, 0);

        for (int s = 0; s < 4096; s++) wr(s, 0, 0, "R4");
        wr(5, 1, 3, "R4");  wr(37, 1, 3, "R4");
        wr(9, 1, 7, "R4");  wr(41, 1, 7, "R4");
        wr(44, 1, 3, "R4"); wr(76, 1, 3, "R4");
        step("R10");

        sched_en = 1;
        // R5: request in the slot-start cycle of slot 5 waits for slot 37
        run_to(5, "R4");
        post(3, 32'hA000_0100, "R5");
        check(!cmd_push, "R5", "late push", cmd_push, 0);
        run_to(6, "R4");
        post(7, 32'hB000_0001, "R8");
        // R8: collision on link 7 at slot 9
        run_to(9, "R4");
        post(7, 32'hB000_0002, "R8");
        check(cmd_push && cmd_link == 7 && cmd_addr == 32'hB000_0001, "R8", "old addr", cmd_addr, 32'hB000_0001);
        run_to(37, "R4");
        step("R5");
        check(cmd_push && cmd_link == 3 && cmd_addr == 32'hA000_0100, "R5", "deferred addr", cmd_addr, 32'hA000_0100);
        run_to(41, "R4");
        step("R8");
        check(cmd_push && cmd_addr == 32'hB000_0002, "R8", "new addr", cmd_addr, 32'hB000_0002);
        // R6: overflow drops the command
        run_to(42, "R4");
        post(3, 32'hC000_0000, "R6");
        run_to(44, "R4");
        cmdq_full = 1;
        step("R6");
        cmdq_full = 0;
        check(ovf_err && !cmd_push && ovf_link == 3, "R6", "overflow", {ovf_err, cmd_push, ovf_link}, {1'b1, 1'b0, 5'd3});
        run_to(76, "R4");
        step("R6");
        check(!cmd_push, "R6", "dropped msg", cmd_push, 0);
        // R7: schedule write while enabled has no effect
        run_to(80, "R4");
        post(3, 32'hD000_0000, "R7");
        run_to(85, "R4");
        wr(90, 1, 3, "R7");
        run_to(90, "R4");
        step("R7");
        check(!cmd_push, "R7", "ignored write", cmd_push, 0);
        // R1: line/column split and wrap
        run_to(100, "R1");
        check(slot_idx[11:5] == 3 && slot_idx[4:0] == 4, "R1", "line/col", slot_idx, 100);
        run_to(4095, "R1");
        repeat (SC) step("R1");
        check(slot_idx == 0, "R1", "wrap", slot_idx, 0);
        // R10: disabled holds slot 0
        sched_en = 0;
        repeat (6) step("R10");
        check(slot_idx == 0 && !cmd_push, "R10", "idle", slot_idx, 0);

        // random periodic schedule
        for (int s = 0; s < 4096; s++) wr(s, 0, 0, "R4");
        for (int l = 0; l < 16; l++) begin
            int g, col, ph;
            bit free;
            g = 1 << ($urandom % 4);
            col = $urandom % 32;
            ph = $urandom % g;
            free = 1;
            for (int ln = ph; ln < 128; ln += g) if (mv[ln*32 + col]) free = 0;
            if (free) for (int ln = ph; ln < 128; ln += g) wr(ln*32 + col, 1, l, "R4");
        end
        sched_en = 1;
        for (int i = 0; i < 2 * 4096 * SC; i++) begin
            req_valid = ($urandom % 4) == 0;
            req_link  = 5'($urandom % 16);
            req_addr  = $urandom;
            cmdq_full = ($urandom % 8) == 0;
            step("R3/R4");
        end
        req_valid = 0; cmdq_full = 0;
        step("R3");

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule